// File: doc/BRIEF.md
# Dual-Clock Prefetching FIFO

This block moves 36-bit words from a write clock domain to an independent read clock domain through a 256-entry storage array. A registered output stage sits in front of the storage. It fetches the oldest stored word on its own, so the first word written appears on the read port without any request. The consumer then sees valid data whenever `out_ready` is high. It takes a word by pulsing `rd_en` for one read-clock cycle.

The two sides exchange pointers only. Each pointer crosses the clock boundary as Gray code through a chain of flip-flops. All four flags are computed in their own domain from the synchronized pointer and then registered. Each flag therefore passes through at least two synchronizing stages plus one flag register before it is seen at a port.

A single active-high reset input is resynchronized into each domain. The write side raises `in_ready` only after the released reset has passed through its synchronizer.

Top module: `dcfifo_prefetch`

## Requirements
- R1: While reset is held, `out_ready` is 0, `almost_empty` is 1, `in_ready` is 0 and `almost_full` is 0. `in_ready` rises within a few write-clock cycles after reset is released.
- R2: A word written into an empty FIFO appears on `rd_data` with `out_ready` high, and no `rd_en` pulse is needed for this.
- R3: Words leave in exactly the order they were written, with their values unchanged.
- R4: A read-clock edge with `out_ready` and `rd_en` both high consumes the presented word. The next stored word is then presented, or `out_ready` drops if none is stored. With `rd_en` low, the output word and `out_ready` stay unchanged.
- R5: The storage holds 256 words and the output register holds one more. With no reads, 257 writes are accepted. `in_ready` is 0 while the storage is full and returns to 1 once a read frees a slot.
- R6: A write strobe while `in_ready` is 0 is ignored: no word is stored and the write pointer does not advance.
- R7: A read strobe while `out_ready` is 0 is ignored: the next word written still appears and is the correct one.
- R8: `almost_empty` is 1 when the total held (storage plus the output register) is at or below 8 words, and 0 above that.
- R9: `almost_full` is 1 when the storage count is at or above 248 (256 minus 8), and 0 below that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset, resynchronized into each domain |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write strobe, taken when `in_ready` is high |
| wr_data | input | 36 | Word to write |
| in_ready | output | 1 | Storage has a free slot (write domain) |
| almost_full | output | 1 | Storage count at or above 248 (write domain) |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read strobe, taken when `out_ready` is high |
| rd_data | output | 36 | Registered output word |
| out_ready | output | 1 | `rd_data` holds a valid word (read domain) |
| almost_empty | output | 1 | Total held at or below 8 (read domain) |

## Verification
A write reaches `out_ready` after two read-clock synchronizer stages plus the loading edge, so about three read-clock edges after the write edge. Freed space reaches `in_ready` after two write-clock stages plus the flag register. The flags therefore settle within a handful of cycles of the opposite clock after a burst. The bench drives a burst, waits a dozen read-clock cycles, and only then samples the flags at falling edges. Data values are checked at a falling read-clock edge before each `rd_en` pulse, when the presented word is stable.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  // Gray conversion on up to 32 bits; callers zero-extend and slice back.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) stg[i] <= stg[i-1];
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DW    = 36,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  // Synchronous read into the output register: this is the prefetch stage.
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AF_OFF = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          push,
  output logic          in_ready,
  output logic          almost_full
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] AF_CNT   = PW'(DEPTH - AF_OFF);

  logic [PW-1:0] wbin, wbin_n, rbin_s, used_n;

  assign push   = wr_en && in_ready;
  assign wbin_n = wbin + PW'(push);
  assign rbin_s = PW'(gray2bin(32'(rgray_s)));
  assign used_n = wbin_n - rbin_s;
  assign waddr  = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      in_ready    <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= wbin_n;
      wgray       <= PW'(bin2gray(32'(wbin_n)));
      in_ready    <= (used_n != FULL_CNT);
      almost_full <= (used_n >= AF_CNT);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_s) <= FULL_CNT);  // R5
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_ready) |=> $stable(wbin));  // R6
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AE_OFF = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          load,
  output logic          out_ready,
  output logic          almost_empty
);
  localparam logic [PW-1:0] AE_CNT = PW'(AE_OFF);

  logic [PW-1:0] rbin, rbin_n, wbin_s, total_n;
  logic          avail, or_n;

  assign wbin_s  = PW'(gray2bin(32'(wgray_s)));
  assign avail   = (wbin_s != rbin);
  // Fetch when the output stage is empty or being consumed this edge.
  assign load    = avail && (!out_ready || rd_en);
  assign rbin_n  = rbin + PW'(load);
  assign or_n    = load || (out_ready && !rd_en);
  assign total_n = (wbin_s - rbin_n) + PW'(or_n);
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      out_ready    <= 1'b0;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_n;
      rgray        <= PW'(bin2gray(32'(rbin_n)));
      out_ready    <= or_n;
      almost_empty <= (total_n <= AE_CNT);
    end
  end

  AST_AE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> almost_empty);  // R8
endmodule

// File: rtl/dcfifo_prefetch.sv
module dcfifo_prefetch #(
  parameter int DW          = 36,
  parameter int DEPTH       = 256,
  parameter int AE_OFF      = 8,
  parameter int AF_OFF      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          rst,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          in_ready,
  output logic          almost_full,
  input  logic          rclk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          out_ready,
  output logic          almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wrst_s, rrst_s, wrst, rrst;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          push, load;

  // Reset takes effect at once and is released through each domain's chain.
  cdc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst_sync (.clk(wclk), .d(rst), .q(wrst_s));
  cdc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst_sync (.clk(rclk), .d(rst), .q(rrst_s));
  assign wrst = rst || wrst_s;
  assign rrst = rst || rrst_s;

  cdc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (.clk(rclk), .d(wgray), .q(wgray_s));
  cdc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (.clk(wclk), .d(rgray), .q(rgray_s));

  dcfifo_wr_ctrl #(.DEPTH(DEPTH), .AF_OFF(AF_OFF)) u_wr (
    .clk(wclk), .rst(wrst), .wr_en(wr_en), .rgray_s(rgray_s),
    .wgray(wgray), .waddr(waddr), .push(push),
    .in_ready(in_ready), .almost_full(almost_full)
  );

  dcfifo_rd_ctrl #(.DEPTH(DEPTH), .AE_OFF(AE_OFF)) u_rd (
    .clk(rclk), .rst(rrst), .rd_en(rd_en), .wgray_s(wgray_s),
    .rgray(rgray), .raddr(raddr), .load(load),
    .out_ready(out_ready), .almost_empty(almost_empty)
  );

  dcfifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(push), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rrst(rrst), .re(load), .raddr(raddr), .rdata(rd_data)
  );

  AST_RD_HOLD: assert property (@(posedge rclk) disable iff (rrst)
    (out_ready && !rd_en) |=> (out_ready && $stable(rd_data)));  // R4
endmodule

// File: tb/dcfifo_prefetch_tb.sv
module dcfifo_prefetch_tb;
  localparam int DW = 36;

  logic rst = 1'b1;
  logic wclk = 1'b0, rclk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic in_ready, almost_full, out_ready, almost_empty;

  int total = 0, bad = 0, wr_idx = 0, rd_idx = 0;
  bit done = 1'b0;

  always #2 wclk = ~wclk;   // 250 MHz
  always #3.5 rclk = ~rclk;

  dcfifo_prefetch u_dut (
    .rst(rst), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data),
    .in_ready(in_ready), .almost_full(almost_full),
    .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data),
    .out_ready(out_ready), .almost_empty(almost_empty)
  );

  function automatic logic [DW-1:0] pat(input int i);
    logic [17:0] v = 18'(i * 37 + 5);
    return {v, ~v};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      while (!in_ready) @(negedge wclk);
      wr_en = 1'b1;
      wr_data = pat(wr_idx);
      @(negedge wclk);
      wr_en = 1'b0;
      wr_idx++;
    end
  endtask

  task automatic do_read(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      while (!out_ready) @(negedge rclk);
      chk("R3 order", 64'(rd_data), 64'(pat(rd_idx)));
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      rd_idx++;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  task automatic chk_flags(input logic [3:0] f);
    @(negedge rclk);
    chk("R4 out_ready", 64'(out_ready), 64'(f[3]));
    chk("R8 almost_empty", 64'(almost_empty), 64'(f[2]));
    @(negedge wclk);
    chk("R5 in_ready", 64'(in_ready), 64'(f[1]));
    chk("R9 almost_full", 64'(almost_full), 64'(f[0]));
    if (f[3]) begin
      @(negedge rclk);
      chk("R2 presented word", 64'(rd_data), 64'(pat(rd_idx)));
    end
  endtask

  // {writes[35:20], reads[19:4], out_ready, almost_empty, in_ready, almost_full}
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {16'd1,   16'd0,   4'b1110},  // 1 held: fall-through
    {16'd8,   16'd0,   4'b1010},  // 9 held
    {16'd0,   16'd1,   4'b1110},  // 8 held: boundary of almost-empty
    {16'd0,   16'd8,   4'b0110},  // empty again
    {16'd257, 16'd0,   4'b1001},  // storage 256 + output register
    {16'd0,   16'd1,   4'b1011},  // storage 255
    {16'd0,   16'd8,   4'b1010},  // storage 247
    {16'd0,   16'd248, 4'b0110}   // drained
  };

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: flags during reset
    repeat (6) @(negedge rclk);
    chk("R1 out_ready in reset", 64'(out_ready), 64'd0);
    chk("R1 almost_empty in reset", 64'(almost_empty), 64'd1);
    @(negedge wclk);
    chk("R1 in_ready in reset", 64'(in_ready), 64'd0);
    chk("R1 almost_full in reset", 64'(almost_full), 64'd0);
    rst = 1'b0;
    repeat (8) @(negedge wclk);
    chk("R1 in_ready after release", 64'(in_ready), 64'd1);
    settle();

    for (int v = 0; v < NV; v++) begin
      do_write(int'(VEC[v][35:20]));
      do_read(int'(VEC[v][19:4]));
      settle();
      chk_flags(VEC[v][3:0]);
    end

    // R6: write strobes while full leave no trace
    do_write(257);
    settle();
    @(negedge wclk);
    chk("R6 full before strobes", 64'(in_ready), 64'd0);
    wr_en = 1'b1;
    wr_data = 36'hBAD_BAD_BA;
    repeat (20) @(negedge wclk);
    wr_en = 1'b0;
    chk("R6 still full", 64'(in_ready), 64'd0);
    do_read(257);
    settle();
    chk("R6 nothing extra stored", 64'(out_ready), 64'd0);

    // R7: read strobes while empty are ignored
    @(negedge rclk);
    rd_en = 1'b1;
    repeat (6) @(negedge rclk);
    rd_en = 1'b0;
    do_write(1);
    settle();
    chk("R7 word presented", 64'(out_ready), 64'd1);
    chk("R7 word value", 64'(rd_data), 64'(pat(rd_idx)));
    do_read(1);
    settle();
    chk("R4 empty after last", 64'(out_ready), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule